// File: doc/BRIEF.md
# PCIe Root Port Power-Up and Link Training Sequencer

This block owns the handful of static control lines that sit between a PCIe root-port core, its PHY and the slot. A single `start_i` pulse runs the whole bring-up. If an earlier run left the link alive, the block first pushes the training state machine back toward detect and switches it off. It then parks the PHY in test power-down, gates the reference clock, and powers the PHY back up, leaving a settling delay before and after the clock returns. Next it holds the endpoint reset for a fixed time. Training starts capped at Gen1. Once that link is up, the cap goes to Gen2, a directed speed change is requested, and the block waits for the core to finish it and for the link to come back.

Every delay is a parameter in clock cycles, so a bench can shrink it. The run ends with a single-cycle `done_o`. `pass_o` gives the result and holds it until the next start. `phase_o` shows the step in progress and reads 0 while the block is idle. A variant without an endpoint reset pin skips the reset hold and keeps the pin high.

Top module: `pcie_rp_bringup`

## Requirements
- R1: When `start_i` is seen in idle while `refclk_en_o` and `ltssm_en_o` are both 1, `force_detect_o` is 1 for exactly the next cycle only. In the cycle after that, `ltssm_en_o` is 0 and `phy_test_pd_o` is 1. If either enable was off at start, `force_detect_o` stays 0.
- R2: `phy_test_pd_o` is 1 in the cycle before `refclk_en_o` falls, and the fall happens one cycle after the power-down step.
- R3: `phy_test_pd_o` falls, and exactly `T_PD_CYC` cycles later `refclk_en_o` rises. `T_CLK_CYC` cycles after that, the endpoint reset is driven low.
- R4: `ep_rst_n_o` is 0 from reset. During a run it is low for exactly `T_EP_RST_CYC` cycles and is then released to 1.
- R5: `max_speed_o` takes the value 1 (Gen1) one cycle before `ltssm_en_o` rises.
- R6: If `link_up_i` is not sampled high within `T_LINK_CYC` cycles after `ltssm_en_o` rises, the run ends with `done_o`=1 and `pass_o`=0. A link seen in the last cycle of that window still counts.
- R7: In the cycle after `link_up_i` is first sampled high, `max_speed_o` reads 2 (Gen2). One cycle later `spd_req_o` rises.
- R8: `spd_req_o` stays high until `spd_busy_i` is sampled low, and then drops. If the link is then sampled up within `T_LINK_CYC` cycles, the run ends with `done_o`=1 and `pass_o`=1.
- R9: If `spd_busy_i` is still high `T_LINK_CYC` cycles after `spd_req_o` rises, `spd_req_o` drops and the run ends with `pass_o`=0. A link that does not return after the speed change fails the same way.
- R10: `done_o` lasts one cycle. `pass_o` keeps its value until the next accepted start. A `start_i` pulse that arrives during a run has no effect on any output.
- R11: While `rst_n` is low: `phy_test_pd_o`=1, `refclk_en_o`=0, `ltssm_en_o`=0, `max_speed_o`=1, `spd_req_o`=0, `force_detect_o`=0, `ep_rst_n_o`=0, `done_o`=0, `pass_o`=0.
- R12: `phase_o` is 0 whenever the block is idle, including after reset and in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, sampled only when idle |
| link_up_i | input | 1 | Core reports link up and training finished |
| spd_busy_i | input | 1 | Directed speed change still pending in the core |
| phy_test_pd_o | output | 1 | PHY test power-down |
| refclk_en_o | output | 1 | PHY reference clock enable |
| ltssm_en_o | output | 1 | Link training state machine enable |
| max_speed_o | output | 4 | Link speed cap: 1 = Gen1, 2 = Gen2 |
| spd_req_o | output | 1 | Directed speed change request |
| force_detect_o | output | 1 | One-cycle request to force link state to detect |
| ep_rst_n_o | output | 1 | Endpoint reset, active low |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Result of the last run |
| phase_o | output | 4 | Current step, 0 when idle |

## Verification
The assertions assume the core raises `spd_busy_i` no later than the clock edge after `spd_req_o` rises. They also assume `link_up_i` and `spd_busy_i` change only between edges and are never glitchy. The stimulus meets these conditions. A partner process drives both inputs on the falling edge and reacts only to the block's own ports: it raises busy on the first falling edge after the request. It also withholds link-up or busy-clear where a timeout path is under test, and places link-up on the last legal cycle and on the first late cycle of the training window.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_HALT     = 4'd1,
      ST_CLK_OFF  = 4'd2,
      ST_PD_CLR   = 4'd3,
      ST_PD_WAIT  = 4'd4,
      ST_CLK_WAIT = 4'd5,
      ST_EP_RST   = 4'd6,
      ST_GEN1     = 4'd7,
      ST_LT_ON    = 4'd8,
      ST_TRAIN1   = 4'd9,
      ST_GEN2     = 4'd10,
      ST_SPEED    = 4'd11,
      ST_TRAIN2   = 4'd12
   } rpb_state_e;

   localparam logic [3:0] SPD_GEN1 = 4'd1;
   localparam logic [3:0] SPD_GEN2 = 4'd2;

   typedef struct packed {
      logic       test_pd;
      logic       refclk;
      logic       ltssm;
      logic [3:0] speed;
      logic       req;
      logic       force_det;
      logic       ep_rst_n;
      logic       done;
      logic       pass;
   } rpb_out_t;

endpackage

// File: rtl/rpb_timer.sv
module rpb_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);

   localparam logic [TW-1:0] ONE = TW'(1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load_i)
         cnt <= val_i;
      else if (cnt != '0)
         cnt <= cnt - ONE;
   end

   assign zero_o = (cnt == '0);

endmodule

// File: rtl/rpb_seq.sv
module rpb_seq
   import rpb_pkg::*;
#(
   parameter int T_PD_CYC     = 2000,
   parameter int T_CLK_CYC    = 40000,
   parameter int T_EP_RST_CYC = 20000000,
   parameter int T_LINK_CYC   = 200000000,
   parameter bit HAS_EP_RST   = 1'b1,
   parameter int TW           = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          link_up_i,
   input  logic          spd_busy_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [TW-1:0] tmr_val_o,
   output rpb_out_t      out_o,
   output rpb_state_e    state_o
);

   localparam logic [TW-1:0] LD_PD   = TW'(T_PD_CYC - 1);
   localparam logic [TW-1:0] LD_CLK  = TW'(T_CLK_CYC - 1);
   localparam logic [TW-1:0] LD_EP   = TW'(T_EP_RST_CYC - 1);
   localparam logic [TW-1:0] LD_LINK = TW'(T_LINK_CYC - 1);

   localparam rpb_out_t OUT_RST = '{
      test_pd:   1'b1,
      refclk:    1'b0,
      ltssm:     1'b0,
      speed:     SPD_GEN1,
      req:       1'b0,
      force_det: 1'b0,
      ep_rst_n:  !HAS_EP_RST,
      done:      1'b0,
      pass:      1'b0
   };

   rpb_state_e st, st_n;
   rpb_out_t   q, d;

   always_comb begin
      st_n        = st;
      d           = q;
      d.force_det = 1'b0;
      d.done      = 1'b0;
      tmr_load_o  = 1'b0;
      tmr_val_o   = '0;
      unique case (st)
         ST_IDLE: begin
            if (start_i) begin
               d.pass = 1'b0;
               if (q.refclk && q.ltssm) begin
                  // a live link is first pushed back toward detect
                  d.force_det = 1'b1;
                  st_n        = ST_HALT;
               end else begin
                  d.test_pd = 1'b1;
                  st_n      = ST_CLK_OFF;
               end
            end
         end
         ST_HALT: begin
            d.ltssm   = 1'b0;
            d.test_pd = 1'b1;
            st_n      = ST_CLK_OFF;
         end
         ST_CLK_OFF: begin
            d.refclk = 1'b0;
            st_n     = ST_PD_CLR;
         end
         ST_PD_CLR: begin
            d.test_pd  = 1'b0;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_PD;
            st_n       = ST_PD_WAIT;
         end
         ST_PD_WAIT: begin
            if (tmr_zero_i) begin
               d.refclk   = 1'b1;
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_CLK;
               st_n       = ST_CLK_WAIT;
            end
         end
         ST_CLK_WAIT: begin
            if (tmr_zero_i) begin
               if (HAS_EP_RST) begin
                  d.ep_rst_n = 1'b0;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = LD_EP;
                  st_n       = ST_EP_RST;
               end else begin
                  st_n = ST_GEN1;
               end
            end
         end
         ST_EP_RST: begin
            if (tmr_zero_i) begin
               d.ep_rst_n = 1'b1;
               st_n       = ST_GEN1;
            end
         end
         ST_GEN1: begin
            d.speed = SPD_GEN1;
            st_n    = ST_LT_ON;
         end
         ST_LT_ON: begin
            d.ltssm    = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_LINK;
            st_n       = ST_TRAIN1;
         end
         ST_TRAIN1: begin
            if (link_up_i) begin
               d.speed = SPD_GEN2;
               st_n    = ST_GEN2;
            end else if (tmr_zero_i) begin
               d.done = 1'b1;
               d.pass = 1'b0;
               st_n   = ST_IDLE;
            end
         end
         ST_GEN2: begin
            d.req      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_LINK;
            st_n       = ST_SPEED;
         end
         ST_SPEED: begin
            if (!spd_busy_i) begin
               d.req      = 1'b0;
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_LINK;
               st_n       = ST_TRAIN2;
            end else if (tmr_zero_i) begin
               d.req  = 1'b0;
               d.done = 1'b1;
               d.pass = 1'b0;
               st_n   = ST_IDLE;
            end
         end
         ST_TRAIN2: begin
            if (link_up_i) begin
               d.done = 1'b1;
               d.pass = 1'b1;
               st_n   = ST_IDLE;
            end else if (tmr_zero_i) begin
               d.done = 1'b1;
               d.pass = 1'b0;
               st_n   = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         q  <= OUT_RST;
      end else begin
         st <= st_n;
         q  <= d;
      end
   end

   assign out_o   = q;
   assign state_o = st;

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
   import rpb_pkg::*;
#(
   parameter int T_PD_CYC     = 2000,
   parameter int T_CLK_CYC    = 40000,
   parameter int T_EP_RST_CYC = 20000000,
   parameter int T_LINK_CYC   = 200000000,
   parameter bit HAS_EP_RST   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       link_up_i,
   input  logic       spd_busy_i,
   output logic       phy_test_pd_o,
   output logic       refclk_en_o,
   output logic       ltssm_en_o,
   output logic [3:0] max_speed_o,
   output logic       spd_req_o,
   output logic       force_detect_o,
   output logic       ep_rst_n_o,
   output logic       done_o,
   output logic       pass_o,
   output logic [3:0] phase_o
);

   localparam int MAX_A = (T_PD_CYC > T_CLK_CYC) ? T_PD_CYC : T_CLK_CYC;
   localparam int MAX_B = (T_EP_RST_CYC > T_LINK_CYC) ? T_EP_RST_CYC : T_LINK_CYC;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW    = (MAX_T < 2) ? 1 : $clog2(MAX_T);

   if (T_PD_CYC < 1 || T_CLK_CYC < 1 || T_EP_RST_CYC < 1 || T_LINK_CYC < 1) begin : g_bad_delay
      $error("pcie_rp_bringup: every delay must be at least one cycle");
   end

   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_zero;
   rpb_out_t      outs;
   rpb_state_e    state;

   rpb_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   rpb_seq #(
      .T_PD_CYC     (T_PD_CYC),
      .T_CLK_CYC    (T_CLK_CYC),
      .T_EP_RST_CYC (T_EP_RST_CYC),
      .T_LINK_CYC   (T_LINK_CYC),
      .HAS_EP_RST   (HAS_EP_RST),
      .TW           (TW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .link_up_i  (link_up_i),
      .spd_busy_i (spd_busy_i),
      .tmr_zero_i (tmr_zero),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .out_o      (outs),
      .state_o    (state)
   );

   assign phy_test_pd_o  = outs.test_pd;
   assign refclk_en_o    = outs.refclk;
   assign ltssm_en_o     = outs.ltssm;
   assign max_speed_o    = outs.speed;
   assign spd_req_o      = outs.req;
   assign force_detect_o = outs.force_det;
   assign ep_rst_n_o     = outs.ep_rst_n;
   assign done_o         = outs.done;
   assign pass_o         = outs.pass;
   assign phase_o        = state;

endmodule

// File: rtl/rpb_chk.sv
module rpb_chk #(
   parameter int T_PD_CYC = 2000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       link_up_i,
   input logic       phy_test_pd_o,
   input logic       refclk_en_o,
   input logic       ltssm_en_o,
   input logic [3:0] max_speed_o,
   input logic       spd_req_o,
   input logic       force_detect_o,
   input logic       ep_rst_n_o,
   input logic       done_o,
   input logic       pass_o,
   input logic [3:0] phase_o
);

   int pd_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pd_low_cnt <= 0;
      else if (phy_test_pd_o)
         pd_low_cnt <= 0;
      else if (pd_low_cnt < T_PD_CYC)
         pd_low_cnt <= pd_low_cnt + 1;
   end

   assert_force_when_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_detect_o) |-> (refclk_en_o && ltssm_en_o));

   assert_force_then_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      force_detect_o |=> (!force_detect_o && !ltssm_en_o && phy_test_pd_o));

   assert_pd_before_clkoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(refclk_en_o) |-> phy_test_pd_o);

   assert_pd_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refclk_en_o) |-> (!phy_test_pd_o && pd_low_cnt >= T_PD_CYC));

   assert_ep_release_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_rst_n_o) |-> refclk_en_o);

   assert_gen1_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ltssm_en_o) |-> (max_speed_o == 4'd1));

   assert_req_at_gen2_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spd_req_o) |-> (max_speed_o == 4'd2 && ltssm_en_o));

   assert_pass_needs_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && pass_o) |-> $past(link_up_i));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_idle_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (phase_o == 4'd0 && !spd_req_o));

endmodule

bind pcie_rp_bringup rpb_chk #(.T_PD_CYC(T_PD_CYC)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .link_up_i      (link_up_i),
   .phy_test_pd_o  (phy_test_pd_o),
   .refclk_en_o    (refclk_en_o),
   .ltssm_en_o     (ltssm_en_o),
   .max_speed_o    (max_speed_o),
   .spd_req_o      (spd_req_o),
   .force_detect_o (force_detect_o),
   .ep_rst_n_o     (ep_rst_n_o),
   .done_o         (done_o),
   .pass_o         (pass_o),
   .phase_o        (phase_o)
);

// File: tb/sim_pcie_rp_bringup.sv
`timescale 1ns/1ps
module sim_pcie_rp_bringup;

   localparam int TPD = 4;
   localparam int TCK = 6;
   localparam int TEP = 8;
   localparam int TLK = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       link_up_i = 1'b0;
   logic       spd_busy_i = 1'b0;
   logic       phy_test_pd_o, refclk_en_o, ltssm_en_o, spd_req_o;
   logic       force_detect_o, ep_rst_n_o, done_o, pass_o;
   logic [3:0] max_speed_o, phase_o;

   always #2.5 clk = ~clk;

   pcie_rp_bringup #(
      .T_PD_CYC(TPD), .T_CLK_CYC(TCK), .T_EP_RST_CYC(TEP),
      .T_LINK_CYC(TLK), .HAS_EP_RST(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_up_i(link_up_i),
      .spd_busy_i(spd_busy_i), .phy_test_pd_o(phy_test_pd_o),
      .refclk_en_o(refclk_en_o), .ltssm_en_o(ltssm_en_o),
      .max_speed_o(max_speed_o), .spd_req_o(spd_req_o),
      .force_detect_o(force_detect_o), .ep_rst_n_o(ep_rst_n_o),
      .done_o(done_o), .pass_o(pass_o), .phase_o(phase_o)
   );

   int checks = 0;
   int errors = 0;
   int case_id = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model: expected outputs per cycle ----------------
   logic       e_pd = 1'b1, e_ref = 1'b0, e_lt = 1'b0, e_req = 1'b0;
   logic       e_force = 1'b0, e_ep = 1'b0, e_done = 1'b0, e_pass = 1'b0;
   logic [3:0] e_spd = 4'd1;

   task automatic step();
      @(posedge clk);
   endtask

   task automatic model_run();
      bit ok;
      e_pass = 1'b0;
      if (e_ref && e_lt) begin
         e_force = 1'b1;
         step();
         e_force = 1'b0;
         e_lt = 1'b0;
      end
      e_pd = 1'b1;
      step(); e_ref = 1'b0;
      step(); e_pd = 1'b0;
      repeat (TPD) step();
      e_ref = 1'b1;
      repeat (TCK) step();
      e_ep = 1'b0;
      repeat (TEP) step();
      e_ep = 1'b1;
      step(); e_spd = 4'd1;
      step(); e_lt = 1'b1;
      ok = 1'b0;
      for (int k = 0; k < TLK; k++) begin
         step();
         if (link_up_i) begin ok = 1'b1; break; end
      end
      if (!ok) begin e_done = 1'b1; return; end
      e_spd = 4'd2;
      step(); e_req = 1'b1;
      ok = 1'b0;
      for (int k = 0; k < TLK; k++) begin
         step();
         if (!spd_busy_i) begin ok = 1'b1; break; end
      end
      e_req = 1'b0;
      if (!ok) begin e_done = 1'b1; return; end
      ok = 1'b0;
      for (int k = 0; k < TLK; k++) begin
         step();
         if (link_up_i) begin ok = 1'b1; break; end
      end
      e_done = 1'b1;
      e_pass = ok;
   endtask

   initial begin
      @(posedge rst_n);
      forever begin
         step();
         e_done = 1'b0;
         if (start_i) model_run();
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(phy_test_pd_o == e_pd, "R2 test_pd", phy_test_pd_o, e_pd);
         chk(refclk_en_o == e_ref, "R3 refclk_en", refclk_en_o, e_ref);
         chk(ltssm_en_o == e_lt, "R5 ltssm_en", ltssm_en_o, e_lt);
         chk(max_speed_o == e_spd, "R7 max_speed", max_speed_o, e_spd);
         chk(spd_req_o == e_req, "R8 spd_req", spd_req_o, e_req);
         chk(ep_rst_n_o == e_ep, "R4 ep_rst_n", ep_rst_n_o, e_ep);
         chk(force_detect_o == e_force, "R1 force_detect", force_detect_o, e_force);
         chk(done_o == e_done, "R10 done", done_o, e_done);
         chk(pass_o == e_pass, "R10 pass", pass_o, e_pass);
      end
   end

   // ---------------- link partner ----------------
   task automatic partner(input int id, input int l1, input int b, input int l2);
      int n;
      n = 0;
      while (!(ltssm_en_o && max_speed_o == 4'd1) && !done_o && n < 1000 && id == case_id) begin
         @(negedge clk); n++;
      end
      if (done_o || l1 < 0 || id != case_id) return;
      repeat (l1) @(negedge clk);
      if (id != case_id) return;
      link_up_i = 1'b1;
      n = 0;
      while (!spd_req_o && !done_o && n < 1000 && id == case_id) begin
         @(negedge clk); n++;
      end
      if (done_o || id != case_id) return;
      spd_busy_i = 1'b1;
      link_up_i = 1'b0;
      if (b < 0) return;
      repeat (b) @(negedge clk);
      if (id != case_id) return;
      spd_busy_i = 1'b0;
      if (l2 < 0) return;
      repeat (l2) @(negedge clk);
      if (id != case_id) return;
      link_up_i = 1'b1;
   endtask

   task automatic run_case(input int l1, input int b, input int l2, input bit exp_pass,
                           input string tag, input bit poke);
      int n;
      int id;
      case_id++;
      id = case_id;
      @(negedge clk);
      link_up_i = 1'b0;
      spd_busy_i = 1'b0;
      fork
         partner(id, l1, b, l2);
      join_none
      if (poke) begin
         fork
            begin
               repeat (20) @(negedge clk);
               start_i = 1'b1;
               @(negedge clk);
               start_i = 1'b0;
            end
         join_none
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 3000) begin
         @(negedge clk); n++;
      end
      chk(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
      chk(pass_o == exp_pass, {tag, " result"}, pass_o, exp_pass);
      @(negedge clk);
      chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
      chk(pass_o == exp_pass, "R10 pass held", pass_o, exp_pass);
      chk(phase_o == 4'd0, "R12 idle phase", phase_o, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(phy_test_pd_o == 1'b1, "R11 reset test_pd", phy_test_pd_o, 1);
      chk(refclk_en_o == 1'b0, "R11 reset refclk", refclk_en_o, 0);
      chk(ltssm_en_o == 1'b0, "R11 reset ltssm", ltssm_en_o, 0);
      chk(max_speed_o == 4'd1, "R11 reset speed", max_speed_o, 1);
      chk(spd_req_o == 1'b0, "R11 reset req", spd_req_o, 0);
      chk(ep_rst_n_o == 1'b0, "R11 reset ep_rst_n", ep_rst_n_o, 0);
      chk(done_o == 1'b0 && pass_o == 1'b0 && force_detect_o == 1'b0,
          "R11 reset done/pass/force", {done_o, pass_o, force_detect_o}, 0);
      chk(phase_o == 4'd0, "R12 reset phase", phase_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case(5, 3, 4, 1'b1, "R8 fresh pass, R10 stray start", 1'b1);
      run_case(2, 1, 1, 1'b1, "R1 recovery pass", 1'b0);
      run_case(-1, 0, 0, 1'b0, "R6 no link", 1'b0);
      run_case(3, -1, 0, 1'b0, "R9 busy stuck", 1'b0);
      run_case(3, 2, -1, 1'b0, "R9 link lost after speed change", 1'b0);
      run_case(TLK - 1, 2, 0, 1'b1, "R6 link on last cycle", 1'b0);
      run_case(TLK, 2, 0, 1'b0, "R6 link one cycle late", 1'b0);
      run_case(0, 1, 0, 1'b1, "R7 immediate link", 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule